// File: doc/BRIEF.md
# Mode-Configurable Output Macrocell

This block is a single output cell of a sum-of-products logic device, together with the two global mode bits that every cell of the device shares. It takes eight product-term results from the AND array and combines them by OR. Depending on the selected mode and its own two configuration bits, it turns that sum into a registered pin, a combinatorial pin with a product-term enable, an always-driven pin, or it switches its driver off so that the pin acts as an input. A per-cell polarity bit picks an active-high or an active-low pin level in every mode. The cell also returns a feedback value to the array.

The register uses the shared device clock and the shared active-low output-enable pin. A synchronous reset models the power-up clear, and a preload port forces any state into the register so that a state machine can be tested from illegal states. The reserved global setting is treated as registered mode and raises an error flag.

Top module: `mode_macrocell`

## Requirements
- R1: The global bits select the mode. `glb_nreg`=0 selects registered mode. `glb_nreg`=1 with `glb_ext`=1 selects complex mode. `glb_nreg`=1 with `glb_ext`=0 selects simple mode.
- R2: The reserved setting (`glb_nreg`=0, `glb_ext`=0) behaves exactly like registered mode and drives `cfg_err`=1. Every other setting drives `cfg_err`=0.
- R3: With `cell_pol`=1 the pin level equals the product-term sum. With `cell_pol`=0 the pin level is its inverse. This holds in every mode.
- R4: In registered mode with `cell_alt`=0, the pin takes the polarity-adjusted OR of all eight terms at each rising clock edge. `pin_oe` equals the inverse of `oe_pin_n` with no delay.
- R5: In registered mode with `cell_alt`=1, and in complex mode whatever `cell_alt` is, the pin is combinatorial. Its value is built from the OR of terms 7..1, and `pin_oe` equals term 0. In complex mode `cell_alt` has no effect.
- R6: In simple mode with `cell_alt`=0, the pin is combinatorial from the OR of all eight terms, and `pin_oe` is always 1.
- R7: In simple mode with `cell_alt`=1, `pin_oe` is 0 and `fb_out` equals `pin_in`.
- R8: When `rst_n` is low at a clock edge, the register state clears to 0. The registered pin then reads 1 for either polarity.
- R9: When `preload_en` is high at a clock edge and reset is not active, the register state takes `preload_val`. The registered pin then reads the inverse of `preload_val`. Reset takes priority over preload, and preload takes priority over the array.
- R10: For a registered cell, `fb_out` is the register state, which is the inverse of the pin level. For a combinatorial cell, `fb_out` is the pin level: `pin_out` while the driver is on, `pin_in` while it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared device clock |
| rst_n | input | 1 | Synchronous active-low power-up clear |
| pterm | input | 8 | Product-term results; term 0 doubles as the enable term |
| glb_nreg | input | 1 | Global mode bit: 0 selects registered operation |
| glb_ext | input | 1 | Global mode bit: 1 selects enable-by-term operation |
| cell_alt | input | 1 | Per-cell configuration bit, meaning depends on mode |
| cell_pol | input | 1 | Per-cell polarity: 1 active high, 0 active low |
| oe_pin_n | input | 1 | Shared active-low output enable for registered cells |
| preload_en | input | 1 | Force the register state on the next edge |
| preload_val | input | 1 | State forced into the register |
| pin_in | input | 1 | Level seen on the pin from outside |
| pin_out | output | 1 | Value the pin driver sends out |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback returned to the array |
| cfg_err | output | 1 | Reserved global setting detected |

## Verification
Single-term patterns are used on purpose. A vector with only term 0 set separates the eight-term sum from the seven-term sum, and it also lights the term-driven enable, so one pattern shows whether registered, complex or simple decoding was applied. Patterns with only term 7 set, or with no terms set, are run under both polarities to show the inversion, and they are clocked to show the one-edge latency of the register against the zero latency of the combinatorial paths. A toggling outside pin level separates pin-sourced feedback from register feedback, and reset, preload and the array are applied together to show which one wins.

// File: rtl/mc_pkg.sv
// Shared types and helpers for the output macrocell.
// Assumes a three-way mode decode; the reserved setting folds into MC_REG.
package mc_pkg;

    typedef enum logic [1:0] {
        MC_REG    = 2'd0,
        MC_CPLX   = 2'd1,
        MC_SIMPLE = 2'd2
    } mc_mode_e;

    // Apply the per-cell polarity to a product-term sum.
    function automatic logic apply_pol(input logic sum, input logic pol);
        return pol ? sum : ~sum;
    endfunction

endpackage

// File: rtl/mc_mode_decode.sv
// Decodes the two global bits into an operating mode.
// Assumes the reserved setting must keep the cell usable: it maps to
// registered mode and raises an error flag.
module mc_mode_decode
    import mc_pkg::*;
(
    input  logic     glb_nreg,
    input  logic     glb_ext,
    output mc_mode_e mode,
    output logic     cfg_err
);

    // Purpose: map the global bits onto a mode and flag the reserved code.
    always_comb begin
        cfg_err = 1'b0;
        if (!glb_nreg) begin
            mode    = MC_REG;
            cfg_err = !glb_ext;
        end else if (glb_ext) begin
            mode = MC_CPLX;
        end else begin
            mode = MC_SIMPLE;
        end
    end

endmodule

// File: rtl/mc_term_or.sv
// ORs a set of product terms. SKIP_FIRST leaves term 0 out of the sum
// when that term is reserved as the enable term.
// Assumes NTERM >= 2.
module mc_term_or #(
    parameter int NTERM      = 8,
    parameter bit SKIP_FIRST = 1'b0
) (
    input  logic [NTERM-1:0] terms,
    output logic             sum
);

    localparam logic [NTERM-1:0] ALL_ONES = {NTERM{1'b1}};
    localparam logic [NTERM-1:0] KEEP     = SKIP_FIRST ? (ALL_ONES << 1) : ALL_ONES;

    // Purpose: reduce the kept terms into a single sum.
    always_comb begin
        sum = |(terms & KEEP);
    end

endmodule

// File: rtl/mc_out_reg.sv
// The cell's state register: clear on reset, forced by preload,
// otherwise loads the array value.
// Assumes the reset is synchronous and active low, and that reset wins
// over preload.
module mc_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic load_val,
    input  logic d,
    output logic q
);

    // Purpose: update the state with priority reset > preload > array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load_en) begin
            q <= load_val;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mode_macrocell.sv
// One output cell of a sum-of-products device. The global mode and the
// per-cell bits choose between a registered pin, a combinatorial pin
// enabled by term 0, an always-driven pin, or a dedicated input.
// Assumes the pin driver sits outside and honours pin_oe, and that
// pin_in reflects the pin level. The register stores the inverse of the
// pin level, so a cleared register shows as a high pin.
module mode_macrocell
    import mc_pkg::*;
#(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTERM-1:0] pterm,
    input  logic             glb_nreg,
    input  logic             glb_ext,
    input  logic             cell_alt,
    input  logic             cell_pol,
    input  logic             oe_pin_n,
    input  logic             preload_en,
    input  logic             preload_val,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb_out,
    output logic             cfg_err
);

    localparam int EN_TERM = 0;

    mc_mode_e mode;
    logic     sum_all;
    logic     sum_data;
    logic     reg_d;
    logic     reg_q;
    logic     comb_all;
    logic     comb_data;

    mc_mode_decode u_decode (
        .glb_nreg (glb_nreg),
        .glb_ext  (glb_ext),
        .mode     (mode),
        .cfg_err  (cfg_err)
    );

    mc_term_or #(.NTERM(NTERM), .SKIP_FIRST(1'b0)) u_or_all (
        .terms (pterm),
        .sum   (sum_all)
    );

    mc_term_or #(.NTERM(NTERM), .SKIP_FIRST(1'b1)) u_or_data (
        .terms (pterm),
        .sum   (sum_data)
    );

    // Purpose: form the polarity-adjusted values and the register input.
    always_comb begin
        comb_all  = apply_pol(sum_all, cell_pol);
        comb_data = apply_pol(sum_data, cell_pol);
        reg_d     = ~comb_all;
    end

    mc_out_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (preload_en),
        .load_val (preload_val),
        .d        (reg_d),
        .q        (reg_q)
    );

    // Purpose: select pin value, enable and feedback per mode.
    always_comb begin
        pin_out = comb_data;
        pin_oe  = pterm[EN_TERM];
        fb_out  = pterm[EN_TERM] ? comb_data : pin_in;
        unique case (mode)
            MC_REG: begin
                if (!cell_alt) begin
                    pin_out = ~reg_q;
                    pin_oe  = !oe_pin_n;
                    fb_out  = reg_q;
                end
            end
            MC_CPLX: begin
                pin_out = comb_data;
            end
            MC_SIMPLE: begin
                pin_out = comb_all;
                pin_oe  = !cell_alt;
                fb_out  = cell_alt ? pin_in : comb_all;
            end
            default: begin
                pin_out = comb_data;
            end
        endcase
    end

endmodule

// File: rtl/mode_macrocell_chk.sv
// Checker for the output macrocell, bound to every instance.
// Assumes access to the register state through the bind connection.
module mode_macrocell_chk #(
    parameter int NTERM = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NTERM-1:0] pterm,
    input logic             glb_nreg,
    input logic             glb_ext,
    input logic             cell_alt,
    input logic             oe_pin_n,
    input logic             preload_en,
    input logic             preload_val,
    input logic             pin_in,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             fb_out,
    input logic             cfg_err,
    input logic             reg_q
);

    assert_simple_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_nreg && !glb_ext && !cell_alt) |-> pin_oe);

    assert_dedicated_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_nreg && !glb_ext && cell_alt) |-> (!pin_oe && fb_out == pin_in));

    assert_shared_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_nreg && !cell_alt) |-> (pin_oe == !oe_pin_n));

    assert_term_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_nreg && glb_ext) |-> (pin_oe == pterm[0]));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_q == 1'b0));

    assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(preload_en)) |-> (reg_q == $past(preload_val)));

    assert_reg_feedback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_nreg && !cell_alt) |-> (fb_out == reg_q && pin_out == !reg_q));

    assert_err_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!glb_nreg && !glb_ext));

endmodule

bind mode_macrocell mode_macrocell_chk #(.NTERM(NTERM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pterm       (pterm),
    .glb_nreg    (glb_nreg),
    .glb_ext     (glb_ext),
    .cell_alt    (cell_alt),
    .oe_pin_n    (oe_pin_n),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out),
    .cfg_err     (cfg_err),
    .reg_q       (reg_q)
);

// File: tb/test_mode_macrocell.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one vector per cycle on the
// falling edge and queues the expected outputs. The monitor pops one
// entry 1 ns after every rising edge and compares it.
module test_mode_macrocell;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pterm = 8'h00;
    logic       glb_nreg = 1'b0;
    logic       glb_ext = 1'b1;
    logic       cell_alt = 1'b0;
    logic       cell_pol = 1'b1;
    logic       oe_pin_n = 1'b0;
    logic       preload_en = 1'b0;
    logic       preload_val = 1'b0;
    logic       pin_in = 1'b0;
    logic       pin_out, pin_oe, fb_out, cfg_err;

    int         checks = 0;
    int         errors = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic       model_pin = 1'b1;  // expected registered pin level
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    mode_macrocell i_mode_macrocell (
        .clk         (clk),
        .rst_n       (rst_n),
        .pterm       (pterm),
        .glb_nreg    (glb_nreg),
        .glb_ext     (glb_ext),
        .cell_alt    (cell_alt),
        .cell_pol    (cell_pol),
        .oe_pin_n    (oe_pin_n),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .fb_out      (fb_out),
        .cfg_err     (cfg_err)
    );

    // Drive one vector and queue the outputs expected after the next edge.
    task automatic step(input logic rn, input logic [7:0] pt, input logic nreg,
                        input logic ext, input logic alt, input logic pol,
                        input logic oen, input logic pre, input logic pv,
                        input logic pin, input string tag);
        logic s8, s7, v, oe, fb, po, err;
        @(negedge clk);
        rst_n = rn; pterm = pt; glb_nreg = nreg; glb_ext = ext; cell_alt = alt;
        cell_pol = pol; oe_pin_n = oen; preload_en = pre; preload_val = pv;
        pin_in = pin;
        s8 = |pt;
        s7 = |pt[7:1];
        if (!rn)       model_pin = 1'b1;
        else if (pre)  model_pin = ~pv;
        else           model_pin = pol ? s8 : ~s8;
        err = !nreg && !ext;
        if (!nreg && !alt) begin
            po = model_pin; oe = !oen; fb = ~model_pin;
        end else if (!nreg || ext) begin
            v = pol ? s7 : ~s7; po = v; oe = pt[0]; fb = oe ? v : pin;
        end else begin
            v = pol ? s8 : ~s8; po = v; oe = !alt; fb = oe ? v : pin;
        end
        exp_q.push_back({po, oe, fb, err});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each queued expectation after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({pin_out, pin_oe, fb_out, cfg_err} !== e) begin
                    errors++;
                    $display("FAIL %s: {pin,oe,fb,err} actual %b expected %b",
                             t, {pin_out, pin_oe, fb_out, cfg_err}, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        //   rn pt     nreg ext alt pol oen pre pv pin
        // R8: reset clears the state, the pin reads high for both polarities
        step(0, 8'h00, 0, 1, 0, 1, 0, 0, 0, 0, "R8 reset pol1");
        step(0, 8'hFF, 0, 1, 0, 0, 0, 0, 0, 0, "R8 reset pol0");
        // R4: the registered pin follows the eight-term sum one edge later
        step(1, 8'h80, 0, 1, 0, 1, 0, 0, 0, 0, "R4 reg term7");
        step(1, 8'h00, 0, 1, 0, 1, 0, 0, 0, 0, "R4 reg none");
        step(1, 8'h01, 0, 1, 0, 1, 0, 0, 0, 0, "R4 R1 reg term0 in sum");
        step(1, 8'h01, 0, 1, 0, 1, 1, 0, 0, 0, "R4 shared oe off");
        // R3: polarity inverts the registered level
        step(1, 8'h01, 0, 1, 0, 0, 0, 0, 0, 0, "R3 reg pol0");
        step(1, 8'h00, 0, 1, 0, 0, 0, 0, 0, 1, "R3 R10 reg pol0 none");
        // R9: preload forces the state, reset wins over it
        step(1, 8'hFF, 0, 1, 0, 1, 0, 1, 1, 0, "R9 preload 1");
        step(1, 8'h00, 0, 1, 0, 1, 0, 1, 0, 0, "R9 preload 0");
        step(0, 8'h00, 0, 1, 0, 0, 0, 1, 1, 0, "R9 R8 reset over preload");
        step(1, 8'h00, 0, 1, 0, 1, 0, 0, 0, 0, "R8 after reset");
        // R5: registered with alt=1 is combinatorial, term 0 is the enable
        step(1, 8'h01, 0, 1, 1, 1, 0, 0, 0, 0, "R5 reg comb term0 only");
        step(1, 8'h03, 0, 1, 1, 1, 0, 0, 0, 1, "R5 reg comb term1");
        step(1, 8'h02, 0, 1, 1, 1, 0, 0, 0, 1, "R5 R10 driver off fb pin");
        // R5: complex mode ignores alt
        step(1, 8'h01, 1, 1, 0, 1, 0, 0, 0, 0, "R5 R1 cplx alt0");
        step(1, 8'h01, 1, 1, 1, 1, 0, 0, 0, 0, "R5 cplx alt1");
        step(1, 8'h81, 1, 1, 1, 0, 0, 0, 0, 1, "R5 R3 cplx pol0");
        step(1, 8'h80, 1, 1, 0, 1, 1, 0, 0, 1, "R5 R10 cplx off fb pin");
        // R6: simple mode is always driven from eight terms
        step(1, 8'h01, 1, 0, 0, 1, 1, 0, 0, 0, "R6 R1 simple term0");
        step(1, 8'h00, 1, 0, 0, 0, 1, 0, 0, 1, "R6 R3 simple pol0");
        // R7: dedicated input, feedback from the pin
        step(1, 8'hFF, 1, 0, 1, 1, 0, 0, 0, 1, "R7 input high");
        step(1, 8'hFF, 1, 0, 1, 1, 0, 0, 0, 0, "R7 input low");
        // R2: reserved setting behaves as registered and flags an error
        step(1, 8'h80, 0, 0, 0, 1, 0, 0, 0, 0, "R2 reserved reg");
        step(1, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0, "R2 reserved next");
        step(1, 8'h02, 0, 0, 1, 1, 0, 0, 0, 1, "R2 reserved comb");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule